// File: doc/BRIEF.md
# Dual-Channel Laser Transmit-Disable and Fault Gating

This block drives the shutdown controls of two laser transmitter channels. Each channel has four inputs that can shut it down: a hardware disable pin, a software disable bit, a transmit-fault input with selectable polarity, and a four-bit vector of monitored alarm flags. Each alarm flag has its own enable bit. From these inputs the block produces a per-channel disable output and a latched fast-shutdown signal. The fast-shutdown signal also puts that channel's bias and modulation DACs into high impedance. The block also produces one combined fault output for both channels.

A disable request is stretched by a fixed number of cycles after it drops. For the whole stretch, the two low alarms tied to the power control loop are masked so that the loop can settle. The transmit-power-low alarm is reported on the combined fault output but never causes a fast shutdown. After reset, an arming timer holds off all fault latching. When the supply is not valid, the disable outputs are released to high impedance.

Alarm bit layout, per channel, is fixed: bit 0 is power high, bit 1 is bias high, bit 2 is power low, bit 3 is bias low. Channel c uses bits [4c+3:4c].

Top module: `laser_txd_gate`

## Requirements
- R1: When hw_dis[c] or sw_dis[c] is high, txd_out[c] is high in that same cycle.
- R2: After the disable request of a channel falls, txd_out[c] stays high for exactly EXT_CYCLES more clock edges and then drops, provided no fault is latched.
- R3: While a channel's extended disable is active, its low alarms (bits 2 and 3) are ignored. They have no effect on fsd_out or fault_out. They act again once the extension ends.
- R4: An alarm whose enable bit in alm_en is 0 has no effect on fsd_out or fault_out.
- R5: The power-low alarm (bit 2) never sets fsd_out. When it is enabled and unmasked, it drives fault_out high.
- R6: Once the arming timer has expired, any of the following sets fsd_out[c] at the next clock edge: an active transmit fault, or an enabled, unmasked power-high, bias-high or bias-low alarm. While fsd_out[c] is high, both dac_hiz[c] and txd_out[c] are high.
- R7: A set fsd_out[c] clears only at the clock edge that follows the falling edge of that channel's extended disable, and only if no shutdown source is active at that time. Otherwise it stays set.
- R8: For the first FRT_CYCLES clock edges after reset, no fault latches and fault_out stays low.
- R9: The active transmit-fault level is txf_in[c] XOR txf_inv[c]. A 1 from this XOR means fault.
- R10: Each bit of txd_oe equals vcc_ok. A 0 means the disable outputs are high impedance.
- R11: During reset, fsd_out, dac_hiz and fault_out are 0, and the stretch and timer counters are cleared.
- R12: The two channels are independent. A fault on one channel does not affect the other channel's txd_out or fsd_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| vcc_ok | input | 1 | Supply above power-on threshold |
| hw_dis | input | NUM_CH | Hardware disable per channel |
| sw_dis | input | NUM_CH | Software disable per channel |
| txf_in | input | NUM_CH | Transmit-fault input per channel |
| txf_inv | input | NUM_CH | Fault polarity invert per channel |
| alm_flags | input | NUM_CH*4 | Monitored alarm flags |
| alm_en | input | NUM_CH*4 | Per-alarm enable bits |
| txd_out | output | NUM_CH | Disable output per channel |
| txd_oe | output | NUM_CH | Output enable for txd_out |
| fsd_out | output | NUM_CH | Latched fast-shutdown per channel |
| dac_hiz | output | NUM_CH | Bias/modulation DAC high-impedance command |
| fault_out | output | 1 | Combined fault indication |

## Verification
The assertions assume that the disable, fault and alarm inputs change only between clock edges, and that reset is held for at least one edge. They also assume that EXT_CYCLES and FRT_CYCLES are at least one. The stretch property only looks at cycles after reset has been released, because a request held through reset starts no stretch. The stimulus drives every input a quarter period after the rising edge and holds reset low across several edges. It runs with short stretch and arming counts, and it clears every latched fault with a disable pulse before the next case starts.

// File: rtl/laser_txd_pkg.sv
package laser_txd_pkg;
  localparam int ALM_W       = 4;
  localparam int BIT_PWR_HI  = 0;
  localparam int BIT_BIAS_HI = 1;
  localparam int BIT_PWR_LO  = 2;
  localparam int BIT_BIAS_LO = 3;

  // alarms muted while the power loop settles
  localparam logic [ALM_W-1:0] LOOP_LOW_MASK = 4'b1100;
  // alarms allowed to trigger fast shutdown (power-low excluded)
  localparam logic [ALM_W-1:0] SHUT_MASK     = 4'b1011;

  function automatic logic [ALM_W-1:0] qualify_alarms(
    input logic [ALM_W-1:0] raw,
    input logic [ALM_W-1:0] en,
    input logic             settling
  );
    logic [ALM_W-1:0] mute;
    mute = settling ? LOOP_LOW_MASK : '0;
    return raw & en & ~mute;
  endfunction

  function automatic logic shutdown_source(
    input logic [ALM_W-1:0] qual,
    input logic             fault_act
  );
    return fault_act | (|(qual & SHUT_MASK));
  endfunction
endpackage

// File: rtl/txd_pulse_stretch.sv
module txd_pulse_stretch #(
  parameter int EXT_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ext
);
  localparam int CW = $clog2(EXT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(EXT_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (req)        cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign ext = req | (cnt != '0);
endmodule

// File: rtl/fault_arm_timer.sv
module fault_arm_timer #(
  parameter int FRT_CYCLES = 6500000
) (
  input  logic clk,
  input  logic rst_n,
  output logic armed
);
  localparam int CW = $clog2(FRT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FRT_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign armed = (cnt == LIMIT);
endmodule

// File: rtl/txd_chan.sv
module txd_chan
  import laser_txd_pkg::*;
#(
  parameter int EXT_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             hw_dis,
  input  logic             sw_dis,
  input  logic             txf_in,
  input  logic             txf_inv,
  input  logic [ALM_W-1:0] alm,
  input  logic [ALM_W-1:0] alm_en,
  output logic             txd,
  output logic             fsd,
  output logic             lo_flag,
  output logic             ext_dis,
  output logic             ext_fall
);
  logic             dis_req;
  logic             fault_act;
  logic [ALM_W-1:0] qual;
  logic             shut_src;
  logic             ext_q;
  logic             flt_q;

  assign dis_req   = hw_dis | sw_dis;
  assign fault_act = txf_in ^ txf_inv;

  txd_pulse_stretch #(.EXT_CYCLES(EXT_CYCLES)) u_stretch (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (dis_req),
    .ext   (ext_dis)
  );

  assign qual     = qualify_alarms(alm, alm_en, ext_dis);
  assign shut_src = shutdown_source(qual, fault_act);
  assign lo_flag  = qual[BIT_PWR_LO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_dis;
  end

  assign ext_fall = ext_q & ~ext_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flt_q <= 1'b0;
    else if (armed && shut_src) flt_q <= 1'b1;
    else if (ext_fall)         flt_q <= 1'b0;
  end

  assign fsd = flt_q;
  assign txd = ext_dis | flt_q;
endmodule

// File: rtl/laser_txd_gate.sv
module laser_txd_gate
  import laser_txd_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int EXT_CYCLES = 1000,
  parameter int FRT_CYCLES = 6500000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vcc_ok,
  input  logic [NUM_CH-1:0]       hw_dis,
  input  logic [NUM_CH-1:0]       sw_dis,
  input  logic [NUM_CH-1:0]       txf_in,
  input  logic [NUM_CH-1:0]       txf_inv,
  input  logic [NUM_CH*ALM_W-1:0] alm_flags,
  input  logic [NUM_CH*ALM_W-1:0] alm_en,
  output logic [NUM_CH-1:0]       txd_out,
  output logic [NUM_CH-1:0]       txd_oe,
  output logic [NUM_CH-1:0]       fsd_out,
  output logic [NUM_CH-1:0]       dac_hiz,
  output logic                    fault_out
);
  logic              armed;
  logic [NUM_CH-1:0] lo_flag;
  logic [NUM_CH-1:0] ext_dis;
  logic [NUM_CH-1:0] ext_fall;

  fault_arm_timer #(.FRT_CYCLES(FRT_CYCLES)) u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (armed)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    txd_chan #(.EXT_CYCLES(EXT_CYCLES)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (armed),
      .hw_dis   (hw_dis[c]),
      .sw_dis   (sw_dis[c]),
      .txf_in   (txf_in[c]),
      .txf_inv  (txf_inv[c]),
      .alm      (alm_flags[c*ALM_W +: ALM_W]),
      .alm_en   (alm_en[c*ALM_W +: ALM_W]),
      .txd      (txd_out[c]),
      .fsd      (fsd_out[c]),
      .lo_flag  (lo_flag[c]),
      .ext_dis  (ext_dis[c]),
      .ext_fall (ext_fall[c])
    );
  end

  assign txd_oe    = {NUM_CH{vcc_ok}};
  assign dac_hiz   = fsd_out;
  assign fault_out = armed & (|(fsd_out | lo_flag));
endmodule

// File: rtl/laser_txd_gate_chk.sv
module laser_txd_gate_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] hw_dis,
  input logic [NUM_CH-1:0] sw_dis,
  input logic [NUM_CH-1:0] txd_out,
  input logic [NUM_CH-1:0] fsd_out,
  input logic              fault_out,
  input logic              armed,
  input logic [NUM_CH-1:0] ext_dis,
  input logic [NUM_CH-1:0] ext_fall
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_p
    a_r1_req_forces_txd: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_dis[c] | sw_dis[c]) |-> txd_out[c]);

    a_r2_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(hw_dis[c] | sw_dis[c])) |-> ext_dis[c]);

    a_r6_fsd_forces_txd: assert property (@(posedge clk) disable iff (!rst_n)
      fsd_out[c] |-> txd_out[c]);

    a_r7_clear_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fsd_out[c]) |-> $past(ext_fall[c]));
  end

  a_r8_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (fsd_out == '0 && !fault_out));

  a_r8_armed_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
endmodule

bind laser_txd_gate laser_txd_gate_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hw_dis    (hw_dis),
  .sw_dis    (sw_dis),
  .txd_out   (txd_out),
  .fsd_out   (fsd_out),
  .fault_out (fault_out),
  .armed     (armed),
  .ext_dis   (ext_dis),
  .ext_fall  (ext_fall)
);

// File: tb/tb_laser_txd_gate.sv
module tb_laser_txd_gate;
  localparam int NCH = 2;
  localparam int EXT = 5;
  localparam int FRT = 20;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           vcc_ok = 1'b1;
  logic [NCH-1:0] hw_dis = '0, sw_dis = '0, txf_in = '0, txf_inv = '0;
  logic [7:0]     alm_flags = '0, alm_en = 8'hFF;
  logic [NCH-1:0] txd_out, txd_oe, fsd_out, dac_hiz;
  logic           fault_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  laser_txd_gate #(.NUM_CH(NCH), .EXT_CYCLES(EXT), .FRT_CYCLES(FRT)) dut (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .hw_dis(hw_dis), .sw_dis(sw_dis),
    .txf_in(txf_in), .txf_inv(txf_inv), .alm_flags(alm_flags), .alm_en(alm_en),
    .txd_out(txd_out), .txd_oe(txd_oe), .fsd_out(fsd_out), .dac_hiz(dac_hiz),
    .fault_out(fault_out)
  );

  // [7]hw [6]sw [5]vcc [4]txf [3]inv [2]exp_txd [1]exp_oe [0]exp_fsd_next
  localparam logic [7:0] VEC [8] = '{
    8'b0010_0010, 8'b1010_0110, 8'b0110_0110, 8'b1100_0100,
    8'b0000_0000, 8'b0011_0011, 8'b0010_1011, 8'b0011_1010
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one-cycle software disable on a channel, then wait out the stretch
  task automatic clear_pulse(input int ch);
    sw_dis[ch] = 1'b1;
    tick(1);
    sw_dis[ch] = 1'b0;
    tick(EXT + 2);
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    alm_flags[0] = 1'b1;            // ch0 power-high present from the start
    tick(3);
    chk("R11 fsd in reset", fsd_out, 0);
    chk("R11 fault in reset", fault_out, 0);
    chk("R11 hiz in reset", dac_hiz, 0);
    chk("R10 oe with vcc", txd_oe, 2'b11);
    rst_n = 1'b1;
    tick(FRT);
    chk("R8 no latch before arm", fsd_out[0], 0);
    chk("R8 fault quiet before arm", fault_out, 0);
    tick(1);
    chk("R6 fsd set", fsd_out[0], 1);
    chk("R6 hiz follows", dac_hiz[0], 1);
    chk("R6 txd forced", txd_out[0], 1);
    chk("R6 fault_out", fault_out, 1);
    chk("R12 other txd", txd_out[1], 0);
    chk("R12 other fsd", fsd_out[1], 0);

    // R7: latched with source gone, cleared only after extended disable falls
    alm_flags = '0;
    tick(2);
    chk("R7 stays latched", fsd_out[0], 1);
    sw_dis[0] = 1'b1;
    tick(1);
    sw_dis[0] = 1'b0;
    tick(EXT);
    chk("R7 held until fall", fsd_out[0], 1);
    tick(1);
    chk("R7 cleared", fsd_out[0], 0);
    chk("R7 txd released", txd_out[0], 0);

    // R7: source still active at the fall keeps it latched
    alm_flags[1] = 1'b1;
    tick(1);
    chk("R6 bias-high sets", fsd_out[0], 1);
    sw_dis[0] = 1'b1;
    tick(1);
    sw_dis[0] = 1'b0;
    tick(EXT + 2);
    chk("R7 kept with source", fsd_out[0], 1);
    alm_flags = '0;
    clear_pulse(0);
    chk("R7 cleared later", fsd_out[0], 0);

    // R1/R2 stretch on ch1
    hw_dis[1] = 1'b1;
    #1;
    chk("R1 hw immediate", txd_out[1], 1);
    tick(2);
    hw_dis[1] = 1'b0;
    #1;
    chk("R2 held at drop", txd_out[1], 1);
    tick(EXT - 1);
    chk("R2 held last", txd_out[1], 1);
    tick(1);
    chk("R2 released", txd_out[1], 0);

    // R3: bias-low masked during extension, active after
    alm_flags[7] = 1'b1;
    hw_dis[1] = 1'b1;
    tick(4);
    chk("R3 bias-low masked", fsd_out[1], 0);
    hw_dis[1] = 1'b0;
    tick(EXT);
    chk("R3 still masked", fsd_out[1], 0);
    tick(1);
    chk("R3 unmasked latches", fsd_out[1], 1);
    alm_flags = '0;
    clear_pulse(1);
    chk("R3 cleanup", fsd_out[1], 0);

    // R5: power-low reports but never shuts down
    alm_flags[6] = 1'b1;
    tick(3);
    chk("R5 no fsd from power-low", fsd_out[1], 0);
    chk("R5 fault_out from power-low", fault_out, 1);
    hw_dis[1] = 1'b1;
    #1;
    chk("R3 power-low masked", fault_out, 0);
    hw_dis[1] = 1'b0;
    alm_flags = '0;
    tick(EXT + 2);

    // R4: disabled alarm ignored
    alm_en[0] = 1'b0;
    alm_flags[0] = 1'b1;
    tick(3);
    chk("R4 disabled alarm fsd", fsd_out[0], 0);
    chk("R4 disabled alarm fault", fault_out, 0);
    alm_flags = '0;
    alm_en = 8'hFF;
    tick(1);

    // table: R1 R9 R10 R6 on ch0
    foreach (VEC[i]) begin
      hw_dis[0] = VEC[i][7];
      sw_dis[0] = VEC[i][6];
      vcc_ok    = VEC[i][5];
      txf_in[0] = VEC[i][4];
      txf_inv[0]= VEC[i][3];
      #1;
      chk("R1 txd", txd_out[0], VEC[i][2]);
      chk("R10 oe", txd_oe, {2{VEC[i][1]}});
      tick(1);
      chk("R9 fsd", fsd_out[0], VEC[i][0]);
      chk("R6 hiz", dac_hiz[0], VEC[i][0]);
      if (VEC[i][0]) chk("R6 txd on fsd", txd_out[0], 1);
      hw_dis[0] = 1'b0; sw_dis[0] = 1'b0; vcc_ok = 1'b1;
      txf_in[0] = 1'b0; txf_inv[0] = 1'b0;
      clear_pulse(0);
    end
    chk("R7 final clear", fsd_out, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule